// File: doc/BRIEF.md
# FIFO Watermark DMA Request Generator

This block sits beside a peripheral FIFO and turns its occupancy into two DMA request lines. A single request says that at least one item can be moved. A burst request says that more items can be moved than a programmable watermark. For a receive FIFO the block counts filled entries. For a transmit FIFO, selected by a parameter, it counts free entries, which are derived from the fill count. Set the watermark equal to the DMA controller's block size, so that one burst request always covers one block.

Both requests are registered and held as levels. Once a request is raised it stays high until the DMA controller asserts its active signal, which is wired to the block's clear input. While clear is high, both lines are low and no new request can form. After clear falls, a request comes back on the next clock edge if its condition still holds. Deasserting the enable drops both lines.

Top module: `fifo_dma_req_gen`

## Requirements
- R1: While `rst_n` is low, `req_single` and `req_burst` are 0, and they remain 0 at the first clock edge after reset.
- R2: At a clock edge where `enable`=1, `req_clear`=0 and the available count is at least 1, `req_single` is 1 after that edge.
- R3: At a clock edge where `enable`=1, `req_clear`=0 and the available count is strictly greater than `watermark`, `req_burst` is 1 after that edge. When the available count equals `watermark`, this does not by itself raise `req_burst`.
- R4: `req_burst`=1 always implies `req_single`=1. Above the watermark both lines rise on the same edge.
- R5: A raised request stays 1 across edges where `enable`=1 and `req_clear`=0, even after the available count falls below its condition.
- R6: After any clock edge where `req_clear`=1, both requests are 0, so no request forms while the DMA is active.
- R7: After `req_clear` returns to 0, a request rises again at the first edge where its condition holds.
- R8: After any clock edge where `enable`=0, both requests are 0.
- R9: The available count is `fifo_level` when `IS_TX`=0. When `IS_TX`=1 it is `DEPTH - fifo_level`, saturating at 0. A full transmit FIFO therefore raises no request, and an empty one with `watermark` < `DEPTH` raises both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Enables request generation |
| fifo_level | input | LVL_W | Number of filled FIFO entries (0..DEPTH) |
| watermark | input | LVL_W | Burst threshold; set equal to the DMA block size |
| req_clear | input | 1 | Clear input, driven by the DMA active signal |
| req_single | output | 1 | Held single-item request |
| req_burst | output | 1 | Held burst request |

## Verification
Every result is due exactly one rising edge after the inputs that cause it. The inputs are applied on the falling edge, and the outputs are compared 1 ns after the next rising edge against a bench model that was advanced at that same edge. The clear handshake is modelled as a DMA that raises clear for one to three cycles after it sees a request. Around that handshake, directed cases cover the watermark equality boundary, holding a request after the level drops, and full and empty transmit FIFOs. Both the receive and the transmit variant run from the same stimulus.

// File: rtl/fifo_dma_req_pkg.sv
package fifo_dma_req_pkg;

   typedef enum int {
      REQ_SINGLE = 0,
      REQ_BURST  = 1
   } req_kind_e;

   localparam int NUM_REQ = 2;

   // free entries of a transmit FIFO, saturating at zero on an illegal count
   function automatic int unsigned free_entries(input int unsigned depth,
                                                input int unsigned filled);
      return (filled >= depth) ? 0 : depth - filled;
   endfunction

endpackage

// File: rtl/fifo_dma_level_adapt.sv
module fifo_dma_level_adapt #(
   parameter int DEPTH = 16,
   parameter bit IS_TX = 1'b0,
   parameter int LVL_W = $clog2(DEPTH + 1)
) (
   input  logic [LVL_W-1:0] fifo_level,
   output logic [LVL_W-1:0] avail
);
   import fifo_dma_req_pkg::*;

   localparam logic [LVL_W-1:0] DEPTH_V = LVL_W'(DEPTH);

   generate
      if (IS_TX) begin : g_tx
         // transmit side: the DMA may write into the free slots
         always_comb begin
            if (fifo_level >= DEPTH_V) avail = '0;
            else                       avail = DEPTH_V - fifo_level;
         end
      end else begin : g_rx
         // receive side: the DMA may read the filled slots
         always_comb avail = fifo_level;
      end
   endgenerate

endmodule

// File: rtl/fifo_dma_threshold.sv
module fifo_dma_threshold #(
   parameter int LVL_W  = 5,
   parameter int NREQ   = 2
) (
   input  logic [LVL_W-1:0] avail,
   input  logic [LVL_W-1:0] watermark,
   output logic [NREQ-1:0]  cond
);
   import fifo_dma_req_pkg::*;

   always_comb begin
      cond             = '0;
      cond[REQ_SINGLE] = (avail != '0);
      cond[REQ_BURST]  = (avail > watermark);
   end

endmodule

// File: rtl/fifo_dma_req_hold.sv
module fifo_dma_req_hold #(
   parameter int NREQ = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            enable,
   input  logic            req_clear,
   input  logic [NREQ-1:0] cond,
   output logic [NREQ-1:0] req_q
);

   generate
      for (genvar g = 0; g < NREQ; g++) begin : g_line
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               req_q[g] <= 1'b0;
            else if (!enable || req_clear)
               req_q[g] <= 1'b0;
            else if (cond[g])
               req_q[g] <= 1'b1;
         end
      end
   endgenerate

endmodule

// File: rtl/fifo_dma_req_gen.sv
module fifo_dma_req_gen #(
   parameter int DEPTH = 16,
   parameter bit IS_TX = 1'b0,
   parameter int LVL_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic [LVL_W-1:0] fifo_level,
   input  logic [LVL_W-1:0] watermark,
   input  logic             req_clear,
   output logic             req_single,
   output logic             req_burst
);
   import fifo_dma_req_pkg::*;

   localparam int NREQ = NUM_REQ;

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("fifo_dma_req_gen: DEPTH must be at least 2");
      end
      if (LVL_W < $clog2(DEPTH + 1)) begin : g_bad_width
         $error("fifo_dma_req_gen: LVL_W too narrow for DEPTH");
      end
   endgenerate

   logic [LVL_W-1:0] avail;
   logic [NREQ-1:0]  cond;
   logic [NREQ-1:0]  req_q;

   fifo_dma_level_adapt #(
      .DEPTH (DEPTH),
      .IS_TX (IS_TX),
      .LVL_W (LVL_W)
   ) adapt_i (
      .fifo_level (fifo_level),
      .avail      (avail)
   );

   fifo_dma_threshold #(
      .LVL_W (LVL_W),
      .NREQ  (NREQ)
   ) thr_i (
      .avail     (avail),
      .watermark (watermark),
      .cond      (cond)
   );

   fifo_dma_req_hold #(
      .NREQ (NREQ)
   ) hold_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .enable    (enable),
      .req_clear (req_clear),
      .cond      (cond),
      .req_q     (req_q)
   );

   assign req_single = req_q[REQ_SINGLE];
   assign req_burst  = req_q[REQ_BURST];

endmodule

// File: rtl/fifo_dma_req_gen_chk.sv
module fifo_dma_req_gen_chk #(
   parameter int DEPTH = 16,
   parameter bit IS_TX = 1'b0,
   parameter int LVL_W = $clog2(DEPTH + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             enable,
   input logic [LVL_W-1:0] fifo_level,
   input logic [LVL_W-1:0] watermark,
   input logic             req_clear,
   input logic             req_single,
   input logic             req_burst
);

   // count the checker derives from the ports, independent of the adapter
   logic [LVL_W:0] chk_avail;
   always_comb begin
      if (!IS_TX)                          chk_avail = {1'b0, fifo_level};
      else if (int'(fifo_level) >= DEPTH)  chk_avail = '0;
      else                                 chk_avail = (LVL_W+1)'(DEPTH) - {1'b0, fifo_level};
   end

   assert_reset_idle_R1: assert property (@(posedge clk)
      !rst_n |=> (!req_single && !req_burst));

   assert_burst_needs_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_burst) |-> $past(chk_avail > {1'b0, watermark}));

   assert_single_needs_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_single) |-> $past(chk_avail != '0));

   assert_burst_implies_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      req_burst |-> req_single);

   assert_hold_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_single && enable && !req_clear) |=> req_single);

   assert_hold_burst_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_burst && enable && !req_clear) |=> req_burst);

   assert_clear_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
      req_clear |=> (!req_single && !req_burst));

   assert_disable_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (!req_single && !req_burst));

endmodule

bind fifo_dma_req_gen fifo_dma_req_gen_chk #(
   .DEPTH (DEPTH),
   .IS_TX (IS_TX),
   .LVL_W (LVL_W)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .enable     (enable),
   .fifo_level (fifo_level),
   .watermark  (watermark),
   .req_clear  (req_clear),
   .req_single (req_single),
   .req_burst  (req_burst)
);

// File: tb/fifo_dma_req_gen_tb_top.sv
`timescale 1ns/1ps
module fifo_dma_req_gen_tb_top;

   localparam int DEPTH = 16;
   localparam int LVL_W = $clog2(DEPTH + 1);

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             enable = 1'b0;
   logic [LVL_W-1:0] fifo_level = '0;
   logic [LVL_W-1:0] watermark = '0;
   logic             req_clear = 1'b0;
   logic             rx_single, rx_burst, tx_single, tx_burst;

   int vectors = 0;
   int miscompares = 0;
   bit done = 1'b0;

   // expected line states
   bit e_rx_s, e_rx_b, e_tx_s, e_tx_b;

   always #2.5 clk = ~clk;

   fifo_dma_req_gen #(.DEPTH(DEPTH), .IS_TX(1'b0)) dut_i (
      .clk(clk), .rst_n(rst_n), .enable(enable), .fifo_level(fifo_level),
      .watermark(watermark), .req_clear(req_clear),
      .req_single(rx_single), .req_burst(rx_burst));

   fifo_dma_req_gen #(.DEPTH(DEPTH), .IS_TX(1'b1)) dut_tx_i (
      .clk(clk), .rst_n(rst_n), .enable(enable), .fifo_level(fifo_level),
      .watermark(watermark), .req_clear(req_clear),
      .req_single(tx_single), .req_burst(tx_burst));

   // available count from R9
   function automatic int avail_of(input bit tx, input int lvl);
      if (!tx) return lvl;
      return (lvl >= DEPTH) ? 0 : DEPTH - lvl;
   endfunction

   // next held state from R2/R3/R5/R6/R8
   function automatic bit next_req(input bit q, input bit cnd, input bit en, input bit clr);
      if (!en || clr) return 1'b0;
      return q | cnd;
   endfunction

   task automatic check(input string tag, input string what, input bit act, input bit exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s %s: actual=%0b expected=%0b (lvl=%0d wm=%0d en=%0b clr=%0b)",
                  tag, what, act, exp, fifo_level, watermark, enable, req_clear);
      end
   endtask

   // one cycle: drive at negedge, advance model at posedge, compare 1 ns later
   task automatic step(input bit en, input int lvl, input int wm, input bit clr, input string tag);
      int ar, at;
      @(negedge clk);
      enable     = en;
      fifo_level = LVL_W'(lvl);
      watermark  = LVL_W'(wm);
      req_clear  = clr;
      @(posedge clk);
      ar = avail_of(1'b0, lvl);
      at = avail_of(1'b1, lvl);
      e_rx_s = next_req(e_rx_s, ar >= 1, en, clr);
      e_rx_b = next_req(e_rx_b, ar > wm, en, clr);
      e_tx_s = next_req(e_tx_s, at >= 1, en, clr);
      e_tx_b = next_req(e_tx_b, at > wm, en, clr);
      #1;
      check(tag, "rx single", rx_single, e_rx_s);
      check(tag, "rx burst",  rx_burst,  e_rx_b);
      check(tag, "tx single", tx_single, e_tx_s);
      check(tag, "tx burst",  tx_burst,  e_tx_b);
   endtask

   initial begin : watchdog
      #(5.0 * 150000);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin : stim
      int clr_left;
      int lvl;
      void'($urandom(32'd20250611));
      // R1: reset state
      repeat (3) @(posedge clk);
      #1;
      check("R1", "rx single in reset", rx_single, 1'b0);
      check("R1", "tx burst in reset",  tx_burst,  1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      e_rx_s = 0; e_rx_b = 0; e_tx_s = 0; e_tx_b = 0;
      step(1'b0, 0, 4, 1'b0, "R1");

      // R3 boundary: level equal to watermark raises single only (rx)
      step(1'b1, 4, 4, 1'b0, "R3");
      check("R3", "rx burst at equality", rx_burst, 1'b0);
      check("R2", "rx single at equality", rx_single, 1'b1);
      // R4: one above watermark raises burst alongside single
      step(1'b1, 5, 4, 1'b0, "R4");
      check("R4", "rx burst above", rx_burst, 1'b1);
      // R5: level drops to zero, both stay held
      step(1'b1, 0, 4, 1'b0, "R5");
      check("R5", "rx burst held", rx_burst, 1'b1);
      // R6: DMA active clears and blocks
      step(1'b1, 9, 4, 1'b1, "R6");
      step(1'b1, 9, 4, 1'b1, "R6");
      check("R6", "rx single blocked", rx_single, 1'b0);
      // R7: reassert once clear falls
      step(1'b1, 9, 4, 1'b0, "R7");
      check("R7", "rx burst back", rx_burst, 1'b1);
      // R8: enable off forces low
      step(1'b0, 9, 4, 1'b0, "R8");
      check("R8", "rx single off", rx_single, 1'b0);
      // R9: full tx FIFO gives no tx request, empty gives both
      step(1'b1, DEPTH, 4, 1'b0, "R9");
      check("R9", "tx single full", tx_single, 1'b0);
      step(1'b1, 0, 0, 1'b1, "R9");
      step(1'b1, 0, DEPTH - 1, 1'b0, "R9");
      check("R9", "tx burst empty", tx_burst, 1'b1);
      check("R9", "rx single empty", rx_single, 1'b0);
      // R3: watermark at DEPTH never yields burst
      step(1'b1, 0, 0, 1'b1, "R3");
      step(1'b1, DEPTH, DEPTH, 1'b0, "R3");
      check("R3", "rx burst wm=DEPTH", rx_burst, 1'b0);

      // random traffic with a modelled DMA handshake (R2..R9)
      clr_left = 0;
      for (int i = 0; i < 4000; i++) begin
         bit en, clr;
         en  = ($urandom_range(0, 19) != 0);
         lvl = int'($urandom_range(0, DEPTH));
         if (clr_left > 0) clr_left--;
         else if ((rx_single || tx_single) && ($urandom_range(0, 2) == 0))
            clr_left = int'($urandom_range(1, 3));
         clr = (clr_left > 0);
         step(en, lvl, int'($urandom_range(0, DEPTH)), clr,
              !en ? "R8" : clr ? "R6" : "R2");
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule